// File: doc/BRIEF.md
# Linked-Descriptor Transfer Sequencer

This block walks a chain of transfer descriptors kept in memory and hands each one in turn to an external data mover. Software gives it a starting descriptor address, picks the byte order, and pulses start. For each descriptor the block reads only the four meaningful words through a single-outstanding word read port. It reverses the byte lanes of each word when big-endian order was chosen. It then offers the source, destination and byte count on a valid/ready output.

Once the mover has taken a descriptor and later signals completion, the block follows the link pointer to the next descriptor. It stops after it has issued a descriptor whose end-of-chain flag is set. A start address or link pointer that does not fall on a 32-byte boundary ends the walk with an alignment error. The address of the descriptor just loaded and its link pointer stay visible on two outputs.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, align_err_o, dsc_valid_o and rd_req_o are 0, and cur_desc_o and next_desc_o are 0.
- R2: Per descriptor the block reads exactly four words, at byte offsets 0x00, 0x08, 0x10 and 0x18 from the descriptor base and in that order. The reserved words at 0x04, 0x0C, 0x14 and 0x1C are never read. A request holds its address until it is granted, and one read response word follows each grant.
- R3: The word at offset 0x00 becomes dsc_src_o, the word at 0x08 becomes dsc_dst_o and the word at 0x18 becomes dsc_cnt_o. The word at 0x10 is the link word, and bit 0 of the link word appears on dsc_last_o. With little-endian order selected, the words are used unchanged.
- R4: With big-endian order selected, every fetched word is byte-reversed before use, so a memory word 0x11223344 gives 0x44332211.
- R5: big_endian_i is sampled only when an accepted start is seen. Changing it during a walk has no effect on the fields.
- R6: While dsc_valid_o is 1 and dsc_ready_i is 0, valid stays 1 and all field outputs hold. Valid falls in the cycle after ready is seen.
- R7: After a descriptor is accepted, no read request is made until a mover_done_i pulse arrives.
- R8: Bit 0 of the link word is the end-of-chain flag. On the mover_done_i for a descriptor with that flag set, done_o pulses for exactly one cycle, busy_o drops in the same cycle, and no further read is made.
- R9: When a descriptor finishes loading, cur_desc_o becomes its address and next_desc_o becomes its link word with the low five bits cleared.
- R10: A start whose address has any of its low five bits set raises align_err_o, leaves the block idle and makes no read.
- R11: If a descriptor without the end flag has a link word with any of bits 4:1 set, align_err_o rises on its mover_done_i. The block then goes idle with no further read and no done pulse.
- R12: A start pulse seen while busy is ignored, and the walk in progress continues unchanged.
- R13: align_err_o stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | Address of the first descriptor |
| big_endian_i | input | 1 | 1 selects byte-reversed word order |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Byte address of the requested word |
| rd_gnt_i | input | 1 | Request accepted |
| rd_rvalid_i | input | 1 | Response word valid |
| rd_rdata_i | input | DW | Response word |
| dsc_valid_o | output | 1 | Descriptor fields valid |
| dsc_ready_i | input | 1 | Mover accepts the fields |
| dsc_src_o | output | DW | Source address |
| dsc_dst_o | output | DW | Destination address |
| dsc_cnt_o | output | DW | Byte count |
| dsc_last_o | output | 1 | Descriptor ends the chain |
| mover_done_i | input | 1 | Mover finished the current descriptor |
| cur_desc_o | output | AW | Address of the descriptor last loaded |
| next_desc_o | output | AW | Link pointer of that descriptor |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse at chain end |
| align_err_o | output | 1 | Alignment error flag |

## Verification
The bench uses the default parameters: 32-bit addresses and words, eight-word descriptors, and the lane-swap variant enabled. With these values the descriptor span is 32 bytes, which makes the five-bit alignment check and the 8-byte field stride the ones the requirements state. The lane-swap path is also built into the design, so big-endian chains can be run next to little-endian ones. A bench memory of 64 words holds four separate chains. Its grant line stalls one cycle in four, which exercises request hold, link following, end-of-chain stop and both error paths.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

   typedef enum logic [1:0] {
      W_IDLE,
      W_FETCH,
      W_ISSUE,
      W_WAIT
   } walk_st_e;

   typedef enum logic [1:0] {
      F_IDLE,
      F_REQ,
      F_RESP
   } fetch_st_e;

   localparam int unsigned FIELD_COUNT = 4;

endpackage

// File: rtl/dcw_lane_swap.sv
module dcw_lane_swap #(
   parameter int unsigned DW      = 32,
   parameter bit          SWAP_EN = 1'b1
) (
   input  logic          be_i,
   input  logic [DW-1:0] word_i,
   output logic [DW-1:0] word_o
);

   localparam int unsigned NB = DW / 8;

   if (DW % 8 != 0) begin : g_bad_width
      $error("dcw_lane_swap: DW must be a multiple of 8");
   end

   if (SWAP_EN) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign word_o[b*8 +: 8] = be_i ? word_i[(NB-1-b)*8 +: 8] : word_i[b*8 +: 8];
      end
   end else begin : g_pass
      logic unused_be;
      assign unused_be = be_i;
      assign word_o    = word_i;
   end

endmodule

// File: rtl/dcw_fetch.sv
module dcw_fetch
   import dcw_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned DW         = 32,
   parameter int unsigned DESC_WORDS = 8,
   parameter bit          SWAP_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] base_i,
   input  logic          be_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_gnt_i,
   input  logic          rd_rvalid_i,
   input  logic [DW-1:0] rd_rdata_i,
   output logic          fin_o,
   output logic [DW-1:0] src_o,
   output logic [DW-1:0] dst_o,
   output logic [DW-1:0] lnk_o,
   output logic [DW-1:0] cnt_o
);

   localparam int unsigned DESC_BYTES = DESC_WORDS * DW / 8;
   localparam int unsigned STRIDE     = DESC_BYTES / FIELD_COUNT;
   localparam int unsigned STRIDE_SH  = $clog2(STRIDE);
   localparam int unsigned IDXW       = $clog2(FIELD_COUNT);

   if ((STRIDE & (STRIDE - 1)) != 0 || STRIDE < DW / 8) begin : g_bad_stride
      $error("dcw_fetch: field stride must be a power of two of at least one word");
   end

   fetch_st_e      st;
   logic [IDXW-1:0] idx;
   logic [AW-1:0]  base_q;
   logic           fin_q;
   logic [DW-1:0]  swapped;
   logic [DW-1:0]  fld [FIELD_COUNT];

   dcw_lane_swap #(.DW(DW), .SWAP_EN(SWAP_EN)) i_swap (
      .be_i   (be_i),
      .word_i (rd_rdata_i),
      .word_o (swapped)
   );

   assign rd_req_o  = (st == F_REQ);
   assign rd_addr_o = base_q + (AW'(idx) << STRIDE_SH);
   assign fin_o     = fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= F_IDLE;
         idx    <= '0;
         base_q <= '0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         unique case (st)
            F_IDLE: if (go_i) begin
               base_q <= base_i;
               idx    <= '0;
               st     <= F_REQ;
            end
            F_REQ: if (rd_gnt_i) st <= F_RESP;
            F_RESP: if (rd_rvalid_i) begin
               if (idx == IDXW'(FIELD_COUNT - 1)) begin
                  fin_q <= 1'b1;
                  st    <= F_IDLE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= F_REQ;
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_fld
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (st == F_RESP && rd_rvalid_i && idx == IDXW'(f)) q <= swapped;
      end
      assign fld[f] = q;
   end

   assign src_o = fld[0];
   assign dst_o = fld[1];
   assign lnk_o = fld[2];
   assign cnt_o = fld[3];

   // R2: a pending request keeps its address until granted
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));

   // R2: no new request while a response is still owed
   a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && rd_gnt_i |=> !rd_req_o);

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import dcw_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned DW         = 32,
   parameter int unsigned DESC_WORDS = 8,
   parameter bit          SWAP_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] start_addr_i,
   input  logic          big_endian_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_gnt_i,
   input  logic          rd_rvalid_i,
   input  logic [DW-1:0] rd_rdata_i,
   output logic          dsc_valid_o,
   input  logic          dsc_ready_i,
   output logic [DW-1:0] dsc_src_o,
   output logic [DW-1:0] dsc_dst_o,
   output logic [DW-1:0] dsc_cnt_o,
   output logic          dsc_last_o,
   input  logic          mover_done_i,
   output logic [AW-1:0] cur_desc_o,
   output logic [AW-1:0] next_desc_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          align_err_o
);

   localparam int unsigned DESC_BYTES = DESC_WORDS * DW / 8;
   localparam int unsigned ALIGN_W    = $clog2(DESC_BYTES);

   if (DW % 8 != 0) begin : g_bad_dw
      $error("dma_chain_walker: DW must be a multiple of 8");
   end
   if (DESC_WORDS % FIELD_COUNT != 0 || (DESC_WORDS & (DESC_WORDS - 1)) != 0) begin : g_bad_words
      $error("dma_chain_walker: DESC_WORDS must be a power of two holding the four fields");
   end
   if (AW > DW || AW <= ALIGN_W || ALIGN_W < 2) begin : g_bad_aw
      $error("dma_chain_walker: AW must fit in a word and exceed the alignment width");
   end

   walk_st_e      st;
   logic [AW-1:0] base_q;
   logic          be_q;
   logic [AW-1:0] cur_q;
   logic [AW-1:0] nxt_q;
   logic          last_q;
   logic          bad_q;
   logic          go_q;
   logic          done_q;
   logic          err_q;

   logic          f_fin;
   logic [DW-1:0] f_lnk;
   logic [AW-1:0] lnk_ptr;

   dcw_fetch #(
      .AW(AW), .DW(DW), .DESC_WORDS(DESC_WORDS), .SWAP_EN(SWAP_EN)
   ) i_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go_q),
      .base_i      (base_q),
      .be_i        (be_q),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .rd_gnt_i    (rd_gnt_i),
      .rd_rvalid_i (rd_rvalid_i),
      .rd_rdata_i  (rd_rdata_i),
      .fin_o       (f_fin),
      .src_o       (dsc_src_o),
      .dst_o       (dsc_dst_o),
      .lnk_o       (f_lnk),
      .cnt_o       (dsc_cnt_o)
   );

   assign lnk_ptr = {f_lnk[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= W_IDLE;
         base_q <= '0;
         be_q   <= 1'b0;
         cur_q  <= '0;
         nxt_q  <= '0;
         last_q <= 1'b0;
         bad_q  <= 1'b0;
         go_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         unique case (st)
            W_IDLE: if (start_i) begin
               if (|start_addr_i[ALIGN_W-1:0]) begin
                  err_q <= 1'b1;
               end else begin
                  err_q  <= 1'b0;
                  be_q   <= big_endian_i;
                  base_q <= start_addr_i;
                  go_q   <= 1'b1;
                  st     <= W_FETCH;
               end
            end
            W_FETCH: if (f_fin) begin
               cur_q  <= base_q;
               nxt_q  <= lnk_ptr;
               last_q <= f_lnk[0];
               bad_q  <= |f_lnk[ALIGN_W-1:1];
               st     <= W_ISSUE;
            end
            W_ISSUE: if (dsc_ready_i) st <= W_WAIT;
            W_WAIT: if (mover_done_i) begin
               if (last_q) begin
                  done_q <= 1'b1;
                  st     <= W_IDLE;
               end else if (bad_q) begin
                  err_q <= 1'b1;
                  st    <= W_IDLE;
               end else begin
                  base_q <= nxt_q;
                  go_q   <= 1'b1;
                  st     <= W_FETCH;
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign dsc_valid_o = (st == W_ISSUE);
   assign dsc_last_o  = last_q;
   assign cur_desc_o  = cur_q;
   assign next_desc_o = nxt_q;
   assign busy_o      = (st != W_IDLE);
   assign done_o      = done_q;
   assign align_err_o = err_q;

   // R6: offered fields hold until accepted
   a_r6_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid_o && !dsc_ready_i |=> dsc_valid_o && $stable(dsc_src_o)
         && $stable(dsc_dst_o) && $stable(dsc_cnt_o) && $stable(dsc_last_o));

   // R7: the read port is quiet while a descriptor is out with the mover
   a_r7_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_ISSUE || st == W_WAIT) |-> !rd_req_o);

   // R8: done lasts one cycle and coincides with idle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !rd_req_o);

   // R9: a loaded descriptor address is always on the alignment grid
   a_r9_cur_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid_o |-> cur_desc_o[ALIGN_W-1:0] == '0 && next_desc_o[ALIGN_W-1:0] == '0);

   // R10/R11: a rising error leaves the block idle without a done pulse
   a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(align_err_o) |-> !busy_o && !done_o);

endmodule

// File: tb/test_dma_chain_walker.sv
`timescale 1ns/1ps
module test_dma_chain_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic        big_endian_i = 1'b0;
   logic        rd_req_o;
   logic [31:0] rd_addr_o;
   logic        rd_gnt_i;
   logic        rd_rvalid_i = 1'b0;
   logic [31:0] rd_rdata_i = '0;
   logic        dsc_valid_o;
   logic        dsc_ready_i = 1'b0;
   logic [31:0] dsc_src_o, dsc_dst_o, dsc_cnt_o;
   logic        dsc_last_o;
   logic        mover_done_i = 1'b0;
   logic [31:0] cur_desc_o, next_desc_o;
   logic        busy_o, done_o, align_err_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dma_chain_walker i_dma_chain_walker (
      .clk, .rst_n, .start_i, .start_addr_i, .big_endian_i,
      .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_rvalid_i, .rd_rdata_i,
      .dsc_valid_o, .dsc_ready_i, .dsc_src_o, .dsc_dst_o, .dsc_cnt_o, .dsc_last_o,
      .mover_done_i, .cur_desc_o, .next_desc_o, .busy_o, .done_o, .align_err_o
   );

   // memory model: 64 words, grant stalls one cycle in four
   logic [31:0] mem [64];
   int          rd_cnt = 0;
   int          rd_bad = 0;
   logic [1:0]  off_idx = '0;
   logic [3:0]  gcnt = '0;
   logic        gnt_ok = 1'b0;

   assign rd_gnt_i = rd_req_o & gnt_ok;

   always @(posedge clk) begin
      gcnt        <= gcnt + 1'b1;
      gnt_ok      <= (gcnt[1:0] != 2'd3);
      rd_rvalid_i <= 1'b0;
      if (rd_req_o && rd_gnt_i) begin
         rd_rvalid_i <= 1'b1;
         rd_rdata_i  <= mem[rd_addr_o[7:2]];
         rd_cnt      <= rd_cnt + 1;
         off_idx     <= off_idx + 1'b1;
         if (rd_addr_o[4:0] != {off_idx, 3'b000} || rd_addr_o[31:8] != '0)
            rd_bad <= rd_bad + 1;
      end
   end

   function automatic logic [31:0] sw32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int base, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] c, input bit be);
      mem[base/4]     = be ? sw32(s) : s;
      mem[base/4 + 2] = be ? sw32(d) : d;
      mem[base/4 + 4] = be ? sw32(n) : n;
      mem[base/4 + 6] = be ? sw32(c) : c;
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic        be;
      logic [3:0]  n;
      logic        err;
      logic        poke;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{32'h24, 1'b0, 4'd0, 1'b1, 1'b0},
      '{32'h40, 1'b0, 4'd3, 1'b0, 1'b1},
      '{32'hC0, 1'b0, 4'd1, 1'b0, 1'b0},
      '{32'hE0, 1'b0, 4'd1, 1'b1, 1'b0},
      '{32'h00, 1'b1, 4'd2, 1'b0, 1'b0}
   };

   task automatic run_vec(input logic [31:0] a, input bit be, input int exp_n,
                          input bit exp_err, input bit poke);
      logic [31:0] p, ws, wd, wn, wc;
      int n, base_rd, at_valid;
      bit fin;
      string t;
      base_rd = rd_cnt;
      t = be ? "R4" : "R3";
      @(negedge clk);
      start_i = 1'b1; start_addr_i = a; big_endian_i = be;
      @(negedge clk);
      start_i = 1'b0; big_endian_i = ~be;   // R5: later changes must not matter
      n = 0; fin = 1'b0;
      if (a[4:0] != 0) begin
         chk(align_err_o == 1'b1, "R10 error flag", align_err_o, 1);
         chk(busy_o == 1'b0, "R10 stays idle", busy_o, 0);
         repeat (6) @(negedge clk);
         chk(rd_cnt == base_rd, "R10 no read", rd_cnt, base_rd);
         fin = 1'b1;
      end else begin
         chk(align_err_o == 1'b0, "R13 error cleared by start", align_err_o, 0);
         chk(busy_o == 1'b1, "R8 busy during walk", busy_o, 1);
      end
      p = a;
      while (!fin) begin
         while (!dsc_valid_o) @(negedge clk);
         ws = mem[p[7:2]]; wd = mem[p[7:2] + 2]; wn = mem[p[7:2] + 4]; wc = mem[p[7:2] + 6];
         if (be) begin
            ws = sw32(ws); wd = sw32(wd); wn = sw32(wn); wc = sw32(wc);
         end
         chk(dsc_src_o == ws, {t, " src"}, dsc_src_o, ws);
         chk(dsc_dst_o == wd, {t, " dst"}, dsc_dst_o, wd);
         chk(dsc_cnt_o == wc, {t, " count (R5 mode held)"}, dsc_cnt_o, wc);
         chk(dsc_last_o == wn[0], {t, " last flag"}, dsc_last_o, wn[0]);
         chk(cur_desc_o == p, "R9 current address", cur_desc_o, p);
         chk(next_desc_o == {wn[31:5], 5'b0}, "R9 next address", next_desc_o, {wn[31:5], 5'b0});
         at_valid = rd_cnt;
         repeat (3) @(negedge clk);
         chk(dsc_valid_o && dsc_src_o == ws && dsc_cnt_o == wc, "R6 hold while not ready",
             dsc_src_o, ws);
         if (poke && n == 0) begin
            start_i = 1'b1; start_addr_i = 32'hC0;
            @(negedge clk);
            start_i = 1'b0;
            chk(cur_desc_o == p && dsc_valid_o, "R12 start while busy ignored", cur_desc_o, p);
         end
         dsc_ready_i = 1'b1;
         @(negedge clk);
         dsc_ready_i = 1'b0;
         chk(dsc_valid_o == 1'b0, "R6 valid drops after ready", dsc_valid_o, 0);
         repeat (4) @(negedge clk);
         chk(rd_cnt == at_valid, "R7 no fetch before mover done", rd_cnt, at_valid);
         mover_done_i = 1'b1;
         @(negedge clk);
         mover_done_i = 1'b0;
         n++;
         if (wn[0]) begin
            chk(done_o == 1'b1, "R8 done pulse", done_o, 1);
            chk(busy_o == 1'b0, "R8 busy falls", busy_o, 0);
            @(negedge clk);
            chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
            repeat (6) @(negedge clk);
            chk(rd_cnt == base_rd + 4*n, "R8 no fetch after last", rd_cnt, base_rd + 4*n);
            fin = 1'b1;
         end else if (wn[4:1] != 0) begin
            chk(align_err_o == 1'b1, "R11 link error", align_err_o, 1);
            chk(busy_o == 1'b0, "R11 idle", busy_o, 0);
            chk(done_o == 1'b0, "R11 no done", done_o, 0);
            repeat (6) @(negedge clk);
            chk(rd_cnt == base_rd + 4*n, "R11 no fetch", rd_cnt, base_rd + 4*n);
            fin = 1'b1;
         end else begin
            p = {wn[31:5], 5'b0};
         end
      end
      chk(n == exp_n, "R8 descriptors issued", n, exp_n);
      chk(align_err_o == exp_err, "R13 error state after walk", align_err_o, exp_err);
      big_endian_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | i;
      put(32'h40, 32'h1111_0040, 32'h2222_0040, 32'h0000_0080, 32'h0000_0100, 1'b0);
      put(32'h80, 32'h1111_0080, 32'h2222_0080, 32'h0000_0020, 32'h0000_0044, 1'b0);
      put(32'h20, 32'h1111_0020, 32'h2222_0020, 32'h0000_0001, 32'h0000_0008, 1'b0);
      put(32'hC0, 32'h3333_00C0, 32'h4444_00C0, 32'h0000_0061, 32'h0000_1000, 1'b0);
      put(32'hE0, 32'h5555_00E0, 32'h6666_00E0, 32'h0000_0064, 32'h0000_0200, 1'b0);
      put(32'h00, 32'h7788_0000, 32'h99AA_0000, 32'h0000_00A0, 32'h1122_3344, 1'b1);
      put(32'hA0, 32'hA1B2_C3D4, 32'h0102_0304, 32'h0000_0001, 32'h0000_0F00, 1'b1);

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && !align_err_o && !dsc_valid_o && !rd_req_o,
          "R1 idle after reset", {busy_o, done_o, align_err_o, dsc_valid_o, rd_req_o}, 0);
      chk(cur_desc_o == 0 && next_desc_o == 0, "R1 address registers cleared", cur_desc_o, 0);

      for (int v = 0; v < NV; v++)
         run_vec(VECS[v].addr, VECS[v].be, int'(VECS[v].n), VECS[v].err, VECS[v].poke);

      chk(rd_bad == 0, "R2 only used words in ascending order", rd_bad, 0);

      // R1: reset in the middle of a walk returns to the idle state
      @(negedge clk);
      start_i = 1'b1; start_addr_i = 32'h40;
      @(negedge clk);
      start_i = 1'b0;
      while (!dsc_valid_o) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy_o && !dsc_valid_o && cur_desc_o == 0, "R1 reset mid-walk",
          {busy_o, dsc_valid_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule